// File: doc/BRIEF.md
# Dual Comparator Interrupt Controller

This block is the digital control logic for a pair of analog voltage comparators. Each comparator returns a raw result bit that is asynchronous to the system clock. The result is 1 when the positive input is above the negative input and 0 otherwise. The block synchronizes each result and drives the per-comparator analog enable and negative-input select. It watches each synchronized result for changes. On a change it sets a sticky flag, and it raises a single shared interrupt request when an enabled flag is set.

Software reaches each comparator through a small configuration register. The register is written through a plain write port and read back through a registered read port. It holds these bits:

- enable
- reference select
- interrupt enable
- output enable
- change flag
- synchronized result (read-only)

After a comparator is turned on, a settling window counts down. During that window change events are ignored and the flag is held clear. A power-mode input keeps the comparators running through idle and power-down, and forces them off in total power-down. The result of comparator 0 can be driven to a port pin.

Top module: `dualcmp_irq_ctrl`

## Requirements
- R1: The result field (read bit 5) and the internal result follow the raw input of an enabled comparator through a two-flop synchronizer. A raw value of 1 reads as 1.
- R2: `refsel_o[i]` is 1 when bit 1 of channel i's configuration is 1 (internal reference) and 0 when that bit is 0 (external pin). The output is registered.
- R3: When an enabled comparator is past its settling window and its synchronized result differs from the previous cycle's value, its flag (read bit 4) becomes 1 and stays 1.
- R4: A write to a channel with data bit 4 equal to 0 clears that channel's flag. Writing 1 to bit 4 leaves the flag unchanged. A change event in the same cycle as a clearing write leaves the flag set.
- R5: `irq_o` is 1 exactly when, one cycle earlier, some channel had its flag set together with its interrupt-enable bit (bit 2).
- R6: `cmp_pin_o` shows channel 0's synchronized result when channel 0 is enabled and its output-enable bit (bit 3) is 1. Otherwise it is 0.
- R7: For SETTLE_CYC cycles after each 0-to-1 change of a channel's effective enable, change events are ignored and the flag is held at 0. SETTLE_CYC is derived from the clock frequency and a 10 us window.
- R8: While a channel is disabled, its result reads 0, it produces no change events, its pin output is low and its `cmp_en_o` bit is 0.
- R9: Power modes are encoded as 0 run, 1 idle, 2 power-down and 3 total power-down. In modes 0, 1 and 2 the enabled comparators keep working. Mode 3 turns every effective enable off while the configuration bits are kept, and leaving mode 3 restarts the settling window.
- R10: After reset every configuration bit, flag and output is 0. `rd_data_o` presents the channel selected by `rd_sel_i` one cycle later. Write bit 0 is enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pwr_mode_i | input | 2 | Power mode: 0 run, 1 idle, 2 power-down, 3 total power-down |
| cmp_raw_i | input | NUM_CMP | Asynchronous raw comparator results |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | SEL_W | Channel addressed by the write |
| wr_data_i | input | 5 | Write data: en, refsel, ie, oe, flag (bit 0 upward) |
| rd_sel_i | input | SEL_W | Channel addressed by the read |
| rd_data_o | output | 6 | Registered read: en, refsel, ie, oe, flag, result (bit 0 upward) |
| cmp_en_o | output | NUM_CMP | Effective enable to each analog comparator |
| refsel_o | output | NUM_CMP | Negative-input select, 1 = internal reference |
| cmp_pin_o | output | 1 | Channel 0 result routed to a port pin |
| irq_o | output | 1 | Shared interrupt request |

## Verification
A flag can be cleared by software in the same cycle that a new change event on that comparator wants to set it.

The bench first sets channel 0's flag. It then toggles the raw input and times the clearing write so that the write is sampled on the same edge where the synchronized result first differs from its delayed copy. The flag read afterwards must be 1 and the interrupt request must stay high.

A plain clearing write with no change event nearby is checked separately and must leave the flag at 0.

// File: rtl/dualcmp_pkg.sv
package dualcmp_pkg;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_IDLE = 2'd1,
    PWR_DOWN = 2'd2,
    PWR_OFF  = 2'd3
  } pwr_mode_e;

  // configuration / readback bit positions
  localparam int CFG_EN   = 0;
  localparam int CFG_REF  = 1;
  localparam int CFG_IE   = 2;
  localparam int CFG_OE   = 3;
  localparam int CFG_FLAG = 4;
  localparam int CFG_OUT  = 5;

  localparam int WR_W = CFG_FLAG + 1;
  localparam int RD_W = CFG_OUT + 1;

  typedef struct packed {
    logic oe;
    logic ie;
    logic refsel;
    logic en;
  } cfg_t;

endpackage

// File: rtl/dualcmp_sync.sv
module dualcmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) shreg_q <= '0;
    else                shreg_q <= {shreg_q[STAGES-2:0], d_i};
  end

  assign q_o = shreg_q[STAGES-1];

endmodule

// File: rtl/dualcmp_settle.sv
module dualcmp_settle #(
  parameter int unsigned CYCLES = 2500
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic busy_o,
  output logic run_o
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic             en_d_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = en_i & ~en_d_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_d_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_d_q <= en_i;
      if (!en_i)            cnt_q <= '0;
      else if (rise)        cnt_q <= CNT_W'(CYCLES);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign run_o  = (cnt_q != '0);
  assign busy_o = rise | run_o;

endmodule

// File: rtl/dualcmp_chan.sv
module dualcmp_chan #(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 2500
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic raw_i,
  input  logic clr_i,
  output logic out_o,
  output logic flag_o,
  output logic busy_o,
  output logic run_o
);

  logic sync_q;
  logic prev_q;
  logic flag_q;
  logic chg;

  dualcmp_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clr_i (~en_i),
    .d_i   (raw_i),
    .q_o   (sync_q)
  );

  dualcmp_settle #(.CYCLES(SETTLE_CYC)) settle_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .busy_o (busy_o),
    .run_o  (run_o)
  );

  assign chg = en_i & ~busy_o & (sync_q ^ prev_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sync_q;
      if (busy_o)     flag_q <= 1'b0;
      else if (chg)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign out_o  = sync_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/dualcmp_irq_ctrl.sv
module dualcmp_irq_ctrl
  import dualcmp_pkg::*;
#(
  parameter int          NUM_CMP     = 2,
  parameter int          SEL_W       = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CLK_FREQ_HZ = 250_000_000,
  parameter int unsigned SETTLE_NS   = 10_000
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [1:0]         pwr_mode_i,
  input  logic [NUM_CMP-1:0] cmp_raw_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [4:0]         wr_data_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [5:0]         rd_data_o,
  output logic [NUM_CMP-1:0] cmp_en_o,
  output logic [NUM_CMP-1:0] refsel_o,
  output logic               cmp_pin_o,
  output logic               irq_o
);

  localparam int unsigned CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int unsigned SETTLE_CYC = (CYC_PER_US * SETTLE_NS) / 1000;

  cfg_t [NUM_CMP-1:0] cfg_q;
  logic [NUM_CMP-1:0] en_eff;
  logic [NUM_CMP-1:0] clr_w;
  logic [NUM_CMP-1:0] out_w;
  logic [NUM_CMP-1:0] flag_w;
  logic [NUM_CMP-1:0] busy_w;
  logic [NUM_CMP-1:0] run_w;
  logic [NUM_CMP-1:0] ie_w;
  logic               all_off;
  logic               oe0;

  assign all_off = (pwr_mode_e'(pwr_mode_i) == PWR_OFF);
  assign oe0     = cfg_q[0].oe;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
    logic wr_hit;
    assign wr_hit    = wr_en_i && (int'(wr_sel_i) == i);
    assign clr_w[i]  = wr_hit && !wr_data_i[CFG_FLAG];
    assign en_eff[i] = cfg_q[i].en & ~all_off;
    assign ie_w[i]   = cfg_q[i].ie;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        cfg_q[i] <= '0;
      end else if (wr_hit) begin
        cfg_q[i].en     <= wr_data_i[CFG_EN];
        cfg_q[i].refsel <= wr_data_i[CFG_REF];
        cfg_q[i].ie     <= wr_data_i[CFG_IE];
        cfg_q[i].oe     <= wr_data_i[CFG_OE];
      end
    end

    dualcmp_chan #(
      .SYNC_STAGES (SYNC_STAGES),
      .SETTLE_CYC  (SETTLE_CYC)
    ) chan_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (en_eff[i]),
      .raw_i  (cmp_raw_i[i]),
      .clr_i  (clr_w[i]),
      .out_o  (out_w[i]),
      .flag_o (flag_w[i]),
      .busy_o (busy_w[i]),
      .run_o  (run_w[i])
    );

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        cmp_en_o[i] <= 1'b0;
        refsel_o[i] <= 1'b0;
      end else begin
        cmp_en_o[i] <= en_eff[i];
        refsel_o[i] <= cfg_q[i].refsel;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_o     <= 1'b0;
      cmp_pin_o <= 1'b0;
      rd_data_o <= '0;
    end else begin
      irq_o     <= |(flag_w & ie_w);
      cmp_pin_o <= oe0 & en_eff[0] & out_w[0];
      if (int'(rd_sel_i) < NUM_CMP)
        rd_data_o <= {out_w[rd_sel_i], flag_w[rd_sel_i], cfg_q[rd_sel_i].oe,
                      cfg_q[rd_sel_i].ie, cfg_q[rd_sel_i].refsel, cfg_q[rd_sel_i].en};
      else
        rd_data_o <= '0;
    end
  end

endmodule

// File: rtl/dualcmp_irq_ctrl_chk.sv
module dualcmp_irq_ctrl_chk #(
  parameter int NUM_CMP = 2
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [1:0]         pwr_mode_i,
  input logic [NUM_CMP-1:0] en_eff,
  input logic [NUM_CMP-1:0] flag_w,
  input logic [NUM_CMP-1:0] ie_w,
  input logic [NUM_CMP-1:0] out_w,
  input logic [NUM_CMP-1:0] run_w,
  input logic [NUM_CMP-1:0] busy_w,
  input logic [NUM_CMP-1:0] clr_w,
  input logic               oe0,
  input logic [NUM_CMP-1:0] cmp_en_o,
  input logic               cmp_pin_o,
  input logic               irq_o
);

  p_irq_set_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (|(flag_w & ie_w)) |=> irq_o);

  p_irq_clr_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !(|(flag_w & ie_w)) |=> !irq_o);

  p_pin_gate_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(oe0 && en_eff[0]) |=> !cmp_pin_o);

  p_total_off_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (pwr_mode_i == 2'd3) |=> (cmp_en_o == '0));

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
    p_window_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      run_w[i] |-> !flag_w[i]);

    p_off_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_eff[i] |=> !out_w[i]);

    p_flag_drop_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(flag_w[i]) |-> ($past(clr_w[i]) || $past(busy_w[i])));
  end

endmodule

bind dualcmp_irq_ctrl dualcmp_irq_ctrl_chk #(.NUM_CMP(NUM_CMP)) chk_i (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .pwr_mode_i (pwr_mode_i),
  .en_eff     (en_eff),
  .flag_w     (flag_w),
  .ie_w       (ie_w),
  .out_w      (out_w),
  .run_w      (run_w),
  .busy_w     (busy_w),
  .clr_w      (clr_w),
  .oe0        (oe0),
  .cmp_en_o   (cmp_en_o),
  .cmp_pin_o  (cmp_pin_o),
  .irq_o      (irq_o)
);

// File: tb/dualcmp_irq_ctrl_tb_top.sv
module dualcmp_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pwr = 2'd0;
  logic [1:0] raw = 2'b00;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [4:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [5:0] rd_data;
  logic [1:0] cmp_en;
  logic [1:0] refsel;
  logic       pin;
  logic       irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dualcmp_irq_ctrl #(.SETTLE_NS(100)) dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .pwr_mode_i (pwr),
    .cmp_raw_i  (raw),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .rd_sel_i   (rd_sel),
    .rd_data_o  (rd_data),
    .cmp_en_o   (cmp_en),
    .refsel_o   (refsel),
    .cmp_pin_o  (pin),
    .irq_o      (irq)
  );

  // scoreboard: kind 0 rd_data, 1 irq, 2 pin, 3 cmp_en, 4 refsel
  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_val(int kind, int exp, string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      int act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = int'(rd_data);
        1:       act = int'(irq);
        2:       act = int'(pin);
        3:       act = int'(cmp_en);
        default: act = int'(refsel);
      endcase
      n_checks++;
      if (act != it.exp) begin
        n_errors++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic wr(logic sel, logic [4:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic sel, int exp, string tag);
    rd_sel = sel;
    step();
    expect_val(0, exp, tag);
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step();
    // R10 reset state
    rd(1'b0, 0, "R10 reset ch0");
    rd(1'b1, 0, "R10 reset ch1");
    expect_val(1, 0, "R10 irq reset");
    expect_val(2, 0, "R10 pin reset");
    expect_val(3, 0, "R10 enable reset");
    step();

    // enable ch0: en, refsel, oe
    wr(1'b0, 5'b01011);
    step();
    expect_val(4, 1, "R2 refsel ch0");
    expect_val(3, 1, "R8 enable out ch0");
    raw[0] = 1'b1;
    step(8);
    // R7 window: result visible, flag held clear
    rd(1'b0, 43, "R7 window flag clear / R1 result");
    step(30);
    rd(1'b0, 43, "R7 no late event");
    // R3 change after window, R5 ie off
    raw[0] = 1'b0;
    step(6);
    rd(1'b0, 27, "R3 flag set on change");
    expect_val(1, 0, "R5 irq masked by ie");
    // R6 pin
    raw[0] = 1'b1;
    step(6);
    expect_val(2, 1, "R6 pin follows result");
    // R4 write 1 to flag keeps it, add ie
    wr(1'b0, 5'b11111);
    step(3);
    expect_val(1, 1, "R5 irq with ie");
    rd(1'b0, 63, "R4 write one keeps flag");
    // R4 plain clear
    wr(1'b0, 5'b01111);
    step(3);
    rd(1'b0, 47, "R4 clear flag");
    expect_val(1, 0, "R5 irq drops after clear");
    // R4 collision: change event and clear on same edge
    raw[0] = 1'b0;
    step(6);
    raw[0] = 1'b1;
    step();
    step();
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 5'b01111;
    step();
    wr_en = 1'b0;
    step(3);
    rd(1'b0, 63, "R4 event wins over clear");
    expect_val(1, 1, "R4 irq held on collision");

    // ch1 shares irq
    wr(1'b1, 5'b00101);
    step(32);
    raw[1] = 1'b1;
    step(6);
    rd(1'b1, 53, "R3 ch1 flag set");
    wr(1'b0, 5'b01111);
    step(3);
    expect_val(1, 1, "R5 shared irq from ch1");
    expect_val(4, 1, "R2 ch1 pin reference");
    wr(1'b1, 5'b00101);
    step(3);
    expect_val(1, 0, "R5 irq low all clear");

    // R6 oe on, ie off; then disable
    wr(1'b0, 5'b01011);
    raw[0] = 1'b0;
    step(6);
    expect_val(2, 0, "R6 pin low result");
    wr(1'b0, 5'b00000);
    step(3);
    expect_val(2, 0, "R8 pin low disabled");
    expect_val(3, 2, "R8 enable out low");
    raw[0] = 1'b1;
    step(6);
    rd(1'b0, 0, "R8 disabled reads zero");
    raw[0] = 1'b0;
    step(6);
    raw[0] = 1'b1;
    step(6);
    rd(1'b0, 0, "R8 no events while off");

    // R9 power modes
    pwr = 2'd1;
    wr(1'b0, 5'b00101);
    step(35);
    raw[0] = 1'b0;
    step(6);
    rd(1'b0, 21, "R9 idle keeps comparator");
    expect_val(1, 1, "R9 irq in idle");
    pwr = 2'd2;
    step(3);
    expect_val(3, 3, "R9 power-down keeps enables");
    pwr = 2'd3;
    step(3);
    expect_val(3, 0, "R9 total power-down forces off");
    rd(1'b0, 21, "R9 config kept in total power-down");
    pwr = 2'd0;
    step(5);
    rd(1'b0, 5, "R9 window restarts flag clear");
    expect_val(1, 0, "R9 irq low after restart");
    step(30);
    raw[0] = 1'b1;
    step(6);
    rd(1'b0, 53, "R1 R3 detect after restart");
    step(2);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule